// File: doc/BRIEF.md
# Table Pointer Offset and Bound Unit

This unit turns a raw, unsigned fixed-point table pointer into a bounded table index and an absolute 8-bit memory address. A 16-bit configuration word selects the integer width of the pointer, how many fractional bits it carries, a signed trim offset, the table length and the table base. The offset is scaled to the chosen pointer width and added to the integer part only. The result is then saturated into the table, and the table base is added to form the address.

The raw pointer arrives in a fixed Q8.3 layout: the integer part sits in bits [10:3] and the fractional part in bits [2:0]. A downstream interpolator takes the bounded index and the surviving fractional bits. A memory port takes the address. Configuration codes that name no table length or no table base raise an error flag and force zero outputs. With the default parameters the outputs are registered, so results appear one clock after the inputs.

Top module: `lut_ptr_bound`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, idx_int, idx_frac and tbl_addr read zero and cfg_err reads 0.
- R2: The pointer-width code sits in cfg_word[7:6]. Codes 0, 1, 2 and 3 keep 5, 6, 7 and 8 integer bits of raw_ptr[10:3]. Integer bits above the selected width are ignored.
- R3: The trim offset is the two's-complement number in cfg_word[15:10]. It is added to the masked integer part after a multiply by 1 for width codes 0 and 1, by 2 for code 2 and by 4 for code 3.
- R4: The table-length code sits in cfg_word[5:3]. Codes 1 to 6 give 32 times the code entries. A sum beyond the last entry yields the last entry (length minus 1), with idx_frac zero.
- R5: A negative sum yields idx_int zero and idx_frac zero.
- R6: The fraction code sits in cfg_word[9:8] and keeps n = 0 to 3 of the top fractional bits of raw_ptr[2:0]. The lower fractional bits read zero. The kept bits pass unchanged when no saturation occurs.
- R7: The table-base code sits in cfg_word[2:0]. tbl_addr equals the code times 32 plus idx_int, modulo 256.
- R8: Table-length codes 0 and 7 and base codes 0 and 1 set cfg_err to 1 and force idx_int, idx_frac and tbl_addr to zero. Valid codes give cfg_err 0.
- R9: The outputs reflect the inputs present at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Configuration word (offset, fraction code, width code, length code, base code) |
| raw_ptr | input | 11 | Raw pointer, Q8.3 unsigned |
| idx_int | output | 8 | Bounded integer table index |
| idx_frac | output | 3 | Fractional bits passed on to interpolation |
| tbl_addr | output | 8 | Absolute memory address |
| cfg_err | output | 1 | Unused table-length or base code |

## Verification
The bench drives sums that land exactly on zero and on the last entry, and sums one step beyond each of those bounds. An off-by-one bound would show up there as an index of length or of minus one that wrapped. It uses negative offsets at the 8-bit width, where a design that failed to sign-extend before scaling would add a large positive step. It sets high integer bits above a narrow width, which an unmasked design would carry into the index. It also uses the top base with a long table, where the address must wrap. It also checks that saturation zeroes the fraction, that kept fractional bits survive unchanged, and that each unused code raises the error and zeroes the address.

// File: rtl/lutp_pkg.sv
package lutp_pkg;
   // Field layout of the configuration word, MSB first.
   typedef struct packed {
      logic [5:0] off;    // signed trim offset
      logic [1:0] frac_n; // number of kept fractional bits
      logic [1:0] psz;    // pointer-width code
      logic [2:0] tsz;    // table-length code
      logic [2:0] sot;    // table-base code
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

   function automatic logic tsz_ok(input logic [2:0] c);
      return (c != 3'd0) && (c != 3'd7);
   endfunction

   function automatic logic sot_ok(input logic [2:0] c);
      return c >= 3'd2;
   endfunction
endpackage

// File: rtl/lutp_cfg_decode.sv
module lutp_cfg_decode
   import lutp_pkg::*;
#(
   parameter int INT_W      = 8,
   parameter int FRAC_W     = 3,
   parameter int ADDR_W     = 8,
   parameter int MIN_PW     = 5,
   parameter int TBL_STEP   = 32,
   parameter int BASE_SHIFT = 5
) (
   input  cfg_t              cfg,
   output logic [INT_W-1:0]  int_mask,
   output logic [1:0]        off_sh,
   output logic [FRAC_W-1:0] frac_mask,
   output logic [INT_W-1:0]  last_idx,
   output logic [ADDR_W-1:0] base,
   output logic              bad
);
   localparam int PW_SPAN = 4;

   if (MIN_PW + PW_SPAN - 1 > INT_W) begin : g_pw_bad
      $error("lutp_cfg_decode: INT_W too small for widest pointer");
   end

   // Integer mask: one bit per generated lane, kept when below selected width.
   for (genvar i = 0; i < INT_W; i++) begin : g_imask
      assign int_mask[i] = (i < (MIN_PW + int'(cfg.psz)));
   end

   // Fraction mask: top n bits of the fraction survive.
   for (genvar k = 0; k < FRAC_W; k++) begin : g_fmask
      assign frac_mask[FRAC_W-1-k] = (k < int'(cfg.frac_n));
   end

   // Offset scale: x1, x1, x2, x4.
   always_comb begin
      unique case (cfg.psz)
         2'd2:    off_sh = 2'd1;
         2'd3:    off_sh = 2'd2;
         default: off_sh = 2'd0;
      endcase
   end

   always_comb begin
      int t;
      t        = int'(cfg.tsz) * TBL_STEP - 1;
      bad      = !(tsz_ok(cfg.tsz) && sot_ok(cfg.sot));
      last_idx = tsz_ok(cfg.tsz) ? INT_W'(t) : '0;
      base     = ADDR_W'(int'(cfg.sot) << BASE_SHIFT);
   end
endmodule

// File: rtl/lutp_off_add.sv
module lutp_off_add #(
   parameter int INT_W = 8,
   parameter int OFF_W = 6,
   parameter int SUM_W = 10
) (
   input  logic [INT_W-1:0]        raw_int,
   input  logic [INT_W-1:0]        int_mask,
   input  logic [OFF_W-1:0]        off,
   input  logic [1:0]              off_sh,
   output logic signed [SUM_W-1:0] adj
);
   if (SUM_W < INT_W + 2 || SUM_W < OFF_W + 4) begin : g_sum_bad
      $error("lutp_off_add: SUM_W cannot hold every sum");
   end

   logic signed [SUM_W-1:0] raw_s;
   logic signed [SUM_W-1:0] off_s;
   logic signed [SUM_W-1:0] off_scaled;

   assign raw_s      = $signed({{(SUM_W-INT_W){1'b0}}, raw_int & int_mask});
   assign off_s      = $signed({{(SUM_W-OFF_W){off[OFF_W-1]}}, off});
   assign off_scaled = off_s <<< off_sh;
   assign adj        = raw_s + off_scaled;
endmodule

// File: rtl/lutp_sat.sv
module lutp_sat #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 3,
   parameter int SUM_W  = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [SUM_W-1:0] adj,
   input  logic [INT_W-1:0]        last_idx,
   input  logic [FRAC_W-1:0]       frac_in,
   input  logic                    bad,
   output logic [INT_W-1:0]        idx,
   output logic [FRAC_W-1:0]       frac,
   output logic                    clamped
);
   logic signed [SUM_W-1:0] last_s;
   logic                    below;
   logic                    above;

   assign last_s = $signed({{(SUM_W-INT_W){1'b0}}, last_idx});
   assign below  = adj[SUM_W-1];
   assign above  = !below && (adj > last_s);

   always_comb begin
      clamped = below || above;
      if (below) begin
         idx  = '0;
         frac = '0;
      end else if (above) begin
         idx  = last_idx;
         frac = '0;
      end else begin
         idx  = adj[INT_W-1:0];
         frac = frac_in;
      end
   end

   // R4
   idx_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bad |-> (idx <= last_idx));
   // R5
   neg_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adj < 0) |-> (idx == '0));
   // R6
   sat_frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clamped |-> (frac == '0));
   // R6
   pass_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clamped |-> (frac == frac_in && idx == adj[INT_W-1:0]));
endmodule

// File: rtl/lut_ptr_bound.sv
module lut_ptr_bound
   import lutp_pkg::*;
#(
   parameter int INT_W      = 8,
   parameter int FRAC_W     = 3,
   parameter int ADDR_W     = 8,
   parameter int OFF_W      = 6,
   parameter int SUM_W      = 10,
   parameter int MIN_PW     = 5,
   parameter int TBL_STEP   = 32,
   parameter int BASE_SHIFT = 5,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CFG_W-1:0]        cfg_word,
   input  logic [INT_W+FRAC_W-1:0] raw_ptr,
   output logic [INT_W-1:0]        idx_int,
   output logic [FRAC_W-1:0]       idx_frac,
   output logic [ADDR_W-1:0]       tbl_addr,
   output logic                    cfg_err
);
   if (OFF_W != 6 || CFG_W != 16) begin : g_cfg_bad
      $error("lut_ptr_bound: configuration layout is fixed at 16 bits");
   end
   if (ADDR_W < BASE_SHIFT + 3) begin : g_addr_bad
      $error("lut_ptr_bound: ADDR_W cannot hold every base");
   end

   cfg_t                    cfg;
   logic [INT_W-1:0]        int_mask;
   logic [1:0]              off_sh;
   logic [FRAC_W-1:0]       frac_mask;
   logic [INT_W-1:0]        last_idx;
   logic [ADDR_W-1:0]       base;
   logic                    bad;
   logic signed [SUM_W-1:0] adj;
   logic [INT_W-1:0]        sat_idx;
   logic [FRAC_W-1:0]       sat_frac;
   logic                    clamped;

   logic [INT_W-1:0]        nxt_idx;
   logic [FRAC_W-1:0]       nxt_frac;
   logic [ADDR_W-1:0]       nxt_addr;

   assign cfg = cfg_t'(cfg_word);

   lutp_cfg_decode #(
      .INT_W(INT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .MIN_PW(MIN_PW),
      .TBL_STEP(TBL_STEP), .BASE_SHIFT(BASE_SHIFT)
   ) u_dec (
      .cfg(cfg), .int_mask(int_mask), .off_sh(off_sh), .frac_mask(frac_mask),
      .last_idx(last_idx), .base(base), .bad(bad)
   );

   lutp_off_add #(.INT_W(INT_W), .OFF_W(OFF_W), .SUM_W(SUM_W)) u_add (
      .raw_int(raw_ptr[INT_W+FRAC_W-1:FRAC_W]), .int_mask(int_mask),
      .off(cfg.off), .off_sh(off_sh), .adj(adj)
   );

   lutp_sat #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) u_sat (
      .clk(clk), .rst_n(rst_n), .adj(adj), .last_idx(last_idx),
      .frac_in(raw_ptr[FRAC_W-1:0] & frac_mask), .bad(bad),
      .idx(sat_idx), .frac(sat_frac), .clamped(clamped)
   );

   always_comb begin
      if (bad) begin
         nxt_idx  = '0;
         nxt_frac = '0;
         nxt_addr = '0;
      end else begin
         nxt_idx  = sat_idx;
         nxt_frac = sat_frac;
         nxt_addr = ADDR_W'(base + ADDR_W'(sat_idx));
      end
   end

   if (OUT_REG) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idx_int  <= '0;
            idx_frac <= '0;
            tbl_addr <= '0;
            cfg_err  <= 1'b0;
            primed   <= 1'b0;
         end else begin
            idx_int  <= nxt_idx;
            idx_frac <= nxt_frac;
            tbl_addr <= nxt_addr;
            cfg_err  <= bad;
            primed   <= 1'b1;
         end
      end

      // R7
      addr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && !cfg_err) |->
         (tbl_addr == ADDR_W'((int'($past(cfg_word[2:0])) << BASE_SHIFT)
                              + int'(idx_int))));
      // R8
      err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_err |-> (tbl_addr == '0 && idx_int == '0 && idx_frac == '0));
      // R8
      err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> (cfg_err == !(tsz_ok($past(cfg_word[5:3]))
                                  && sot_ok($past(cfg_word[2:0])))));
   end else begin : g_comb
      assign idx_int  = nxt_idx;
      assign idx_frac = nxt_frac;
      assign tbl_addr = nxt_addr;
      assign cfg_err  = bad;

      // R8
      err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_err |-> (tbl_addr == '0 && idx_int == '0));
   end
endmodule

// File: tb/tb_lut_ptr_bound.sv
module tb_lut_ptr_bound;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic [10:0] raw_ptr = '0;
   logic [7:0]  idx_int;
   logic [2:0]  idx_frac;
   logic [7:0]  tbl_addr;
   logic        cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lut_ptr_bound dut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .raw_ptr(raw_ptr),
      .idx_int(idx_int), .idx_frac(idx_frac), .tbl_addr(tbl_addr),
      .cfg_err(cfg_err)
   );

   function automatic logic [15:0] mk(input int off, input int fn,
                                      input int ps, input int ts, input int st);
      logic [5:0] o;
      o = 6'(off);
      return {o, 2'(fn), 2'(ps), 3'(ts), 3'(st)};
   endfunction

   // Reference from the requirements.
   task automatic expect_of(input logic [15:0] c, input logic [10:0] r,
                            output logic [7:0] ei, output logic [2:0] ef,
                            output logic [7:0] ea, output logic ee);
      int pw, mask, off, mul, sum, len, nf, fm, ts, st;
      off = int'($signed(c[15:10]));
      nf  = int'(c[9:8]);
      pw  = 5 + int'(c[7:6]);
      ts  = int'(c[5:3]);
      st  = int'(c[2:0]);
      mask = (1 << pw) - 1;
      mul = (c[7:6] == 2'd2) ? 2 : (c[7:6] == 2'd3) ? 4 : 1;
      sum = (int'(r[10:3]) & mask) + off * mul;
      len = 32 * ts;
      fm  = (8 - (8 >> nf)) & 7;
      ee  = (ts == 0) || (ts == 7) || (st < 2);
      if (ee) begin
         ei = 0; ef = 0; ea = 0;
      end else begin
         if (sum < 0) begin
            ei = 0; ef = 0;
         end else if (sum > len - 1) begin
            ei = 8'(len - 1); ef = 0;
         end else begin
            ei = 8'(sum); ef = 3'(int'(r[2:0]) & fm);
         end
         ea = 8'(st * 32 + int'(ei));
      end
   endtask

   task automatic check(input string req, input string what,
                        input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   // Drive at falling edge, sample at the next falling edge.
   task automatic run(input string req, input logic [15:0] c, input logic [10:0] r);
      logic [7:0] ei; logic [2:0] ef; logic [7:0] ea; logic ee;
      @(negedge clk);
      cfg_word = c;
      raw_ptr  = r;
      @(negedge clk);
      expect_of(c, r, ei, ef, ea, ee);
      check(req, "idx_int", int'(idx_int), int'(ei));
      check(req, "idx_frac", int'(idx_frac), int'(ef));
      check(req, "tbl_addr", int'(tbl_addr), int'(ea));
      check(req, "cfg_err", int'(cfg_err), int'(ee));
   endtask

   task automatic t_reset;
      cfg_word = mk(8, 0, 0, 1, 2);
      raw_ptr  = {8'd3, 3'd0};
      repeat (3) @(negedge clk);
      check("R1", "idx_int in reset", int'(idx_int), 0);
      check("R1", "tbl_addr in reset", int'(tbl_addr), 0);
      check("R1", "cfg_err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      #1;
      check("R1", "idx_int after release", int'(idx_int), 0);
   endtask

   task automatic t_example;
      // offset +8, raw 3, 5-bit, 32 entries, base 0x40 -> 11, 0x4B
      run("R7", mk(8, 0, 0, 1, 2), {8'd3, 3'd0});
      check("R7", "literal addr", int'(tbl_addr), 8'h4B);
      check("R3", "literal idx", int'(idx_int), 11);
   endtask

   task automatic t_mask;
      // R2: bits above width ignored
      run("R2", mk(0, 0, 0, 6, 2), {8'b1110_0101, 3'd0});
      check("R2", "5-bit keeps 5", int'(idx_int), 5);
      run("R2", mk(0, 0, 1, 6, 2), {8'b1110_0101, 3'd0});
      run("R2", mk(0, 0, 2, 6, 2), {8'b1110_0101, 3'd0});
      run("R2", mk(0, 0, 3, 6, 2), {8'b1010_0101, 3'd0});
   endtask

   task automatic t_scale;
      // R3: -1 at width 8 steps by 4
      run("R3", mk(-1, 0, 3, 4, 2), {8'd100, 3'd0});
      check("R3", "x4 neg", int'(idx_int), 96);
      run("R3", mk(31, 0, 2, 4, 3), {8'd10, 3'd0});
      check("R3", "x2 pos", int'(idx_int), 72);
      run("R3", mk(-32, 0, 1, 2, 3), {8'd40, 3'd0});
      run("R3", mk(-32, 0, 3, 6, 4), {8'd200, 3'd0});
   endtask

   task automatic t_high;
      run("R4", mk(0, 3, 0, 1, 2), {8'd31, 3'b101});
      check("R4", "exact last keeps frac", int'(idx_frac), 5);
      run("R4", mk(1, 3, 0, 1, 2), {8'd31, 3'b101});
      check("R4", "past end to last", int'(idx_int), 31);
      check("R4", "sat frac zero", int'(idx_frac), 0);
      run("R4", mk(31, 0, 3, 6, 2), {8'd255, 3'd0});
      check("R4", "192 last", int'(idx_int), 191);
      run("R4", mk(0, 0, 3, 5, 2), {8'd160, 3'd0});
   endtask

   task automatic t_low;
      run("R5", mk(-3, 2, 0, 1, 2), {8'd3, 3'b110});
      check("R5", "exact zero keeps frac", int'(idx_frac), 6);
      run("R5", mk(-4, 2, 0, 1, 2), {8'd3, 3'b110});
      check("R5", "neg floor", int'(idx_int), 0);
      check("R5", "neg frac zero", int'(idx_frac), 0);
   endtask

   task automatic t_frac;
      for (int n = 0; n < 4; n++) begin
         run("R6", mk(2, n, 0, 1, 2), {8'd4, 3'b111});
      end
      run("R6", mk(0, 1, 0, 1, 2), {8'd4, 3'b011});
      check("R6", "one bit kept", int'(idx_frac), 0);
   endtask

   task automatic t_wrap;
      run("R7", mk(0, 0, 3, 6, 7), {8'd40, 3'd0});
      check("R7", "wrap addr", int'(tbl_addr), 8);
      run("R7", mk(0, 0, 1, 2, 5), {8'd63, 3'd0});
   endtask

   task automatic t_err;
      run("R8", mk(5, 0, 0, 0, 2), {8'd9, 3'd0});
      run("R8", mk(5, 0, 0, 7, 3), {8'd9, 3'd0});
      run("R8", mk(5, 0, 0, 1, 0), {8'd9, 3'd0});
      run("R8", mk(5, 3, 0, 1, 1), {8'd9, 3'b111});
      check("R8", "err set", int'(cfg_err), 1);
      check("R8", "addr zero", int'(tbl_addr), 0);
   endtask

   task automatic t_latency;
      run("R9", mk(0, 0, 0, 1, 2), {8'd7, 3'd0});
      @(negedge clk);
      cfg_word = mk(0, 0, 0, 1, 2);
      raw_ptr  = {8'd20, 3'd0};
      #1;
      check("R9", "held before edge", int'(idx_int), 7);
      @(negedge clk);
      check("R9", "updated after edge", int'(idx_int), 20);
   endtask

   initial begin
      t_reset();
      t_example();
      t_mask();
      t_scale();
      t_high();
      t_low();
      t_frac();
      t_wrap();
      t_err();
      t_latency();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule